// File: doc/BRIEF.md
# Configuration Image Store with Security Lock

This block holds the nonvolatile configuration image of a small programmable logic device: the AND-array connection bitmap, the architecture bits (a global mode pair plus a polarity bit and a register-select bit for every macrocell) and a 64-bit user signature. Every part of the image sits in one flat word store. A single lock bit guards it. Commands arrive on a one-cycle command port with an operation code, a word address and a data word. Each command is accepted or refused in the cycle it is presented, and a response follows one cycle later.

Programming works like an erasable fuse map. A bulk erase returns every stored bit to its erased level of 1, which leaves every array connection open. A program command can only clear bits, so clearing a bit again needs a fresh erase. After the lock is set, reads and program commands are refused. A bulk erase is still allowed while locked, and it wipes the whole image and releases the lock. The architecture bits are decoded continuously onto output pins for the neighbouring macrocell logic.

Top module: `cfg_image_store`

## Requirements
- R1: After reset, `busy`, `locked` and `rsp_valid` are 0, every stored word holds all ones, so `glb_mode` reads 2'b11 and `cell_cfg` reads all ones.
- R2: Every cycle with `cmd_valid` high produces exactly one cycle of `rsp_valid` on the next cycle. `rsp_valid` is 0 after a cycle without a command.
- R3: A bulk erase (`cmd_op` 2'b00) sets every word of the array, signature and architecture regions to all ones and clears `locked`. It is accepted while locked, and its response has `rsp_err` 0.
- R4: After an erase is accepted, `busy` is high from the next cycle for exactly ERASE_CYCLES cycles (default 8).
- R5: A command presented while `busy` is high is refused with `rsp_err` 1 and has no effect. A second erase does not restart the busy window.
- R6: A program command (`cmd_op` 2'b01) stores the bitwise AND of the old word and `cmd_wdata`. Bits can only go from 1 to 0.
- R7: A read command (`cmd_op` 2'b10) returns the stored word on `rsp_rdata` with `rsp_err` 0. `rsp_rdata` is 0 in any response other than a successful read.
- R8: A lock command (`cmd_op` 2'b11) sets `locked` with `rsp_err` 0, also when the lock is already set. While locked, reads and programs to any region, signature included, are refused with `rsp_err` 1 and leave the image unchanged.
- R9: A read or program to an address beyond the last stored word is refused with `rsp_err` 1.
- R10: Address map: array words at 0 to FUSE_WORDS-1 (0-127), signature words at the next SIG_BITS/DATA_W addresses (128-131), architecture words after that (132-133).
- R11: Architecture words are joined with the lower address in the lower bits. Bits [1:0] drive `glb_mode`. For macrocell i, bit 2+2i (polarity) and bit 3+2i (register select) drive `cell_cfg[2i]` and `cell_cfg[2i+1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 erase, 01 program, 10 read, 11 lock |
| cmd_addr | input | ADDR_W (8) | Word address |
| cmd_wdata | input | DATA_W (16) | Program data |
| busy | output | 1 | Erase in progress |
| locked | output | 1 | Security lock state |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Command refused |
| rsp_rdata | output | DATA_W (16) | Read data |
| glb_mode | output | 2 | Global mode bits |
| cell_cfg | output | 2*MACROCELLS (16) | Per-macrocell polarity and register-select bits |

## Verification
The bench targets the lock boundary. It programs the architecture region while locked and checks that `cell_cfg` has not moved. A store that ignored the lock for writes would change those pins even though its reads looked refused. A program issued during the erase window, followed by a second erase, checks two faults at once: a design that restarted the busy counter would stay busy longer than ERASE_CYCLES, and one that let commands through while busy would leave cleared bits after the erase. Repeated programs of the same word catch a store that overwrites instead of ANDing. Reads of the last word of each region and of the first address past the store catch off-by-one errors in the region decode.

// File: rtl/cfgstore_pkg.sv
package cfgstore_pkg;

   typedef enum logic [1:0] {
      OP_ERASE = 2'b00,
      OP_PROG  = 2'b01,
      OP_READ  = 2'b10,
      OP_LOCK  = 2'b11
   } cfg_op_e;

   localparam int GLB_MODE_BITS = 2;
   localparam int BITS_PER_CELL = 2;

endpackage

// File: rtl/cfg_cmd_policy.sv
module cfg_cmd_policy import cfgstore_pkg::*; #(
   parameter int ADDR_W      = 8,
   parameter int TOTAL_WORDS = 134,
   localparam int IDX_W      = $clog2(TOTAL_WORDS)
) (
   input  logic              cmd_valid,
   input  cfg_op_e           cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              busy,
   input  logic              locked,
   output logic              do_erase,
   output logic              do_prog,
   output logic              do_read,
   output logic              do_lock,
   output logic              refuse,
   output logic [IDX_W-1:0]  idx
);

   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(TOTAL_WORDS - 1);

   logic addr_ok;

   assign addr_ok = (cmd_addr <= LAST_ADDR);
   assign idx     = cmd_addr[IDX_W-1:0];

   always_comb begin
      do_erase = 1'b0;
      do_prog  = 1'b0;
      do_read  = 1'b0;
      do_lock  = 1'b0;
      refuse   = 1'b0;
      if (cmd_valid) begin
         if (busy) begin
            refuse = 1'b1;
         end else begin
            unique case (cmd_op)
               OP_ERASE: do_erase = 1'b1;
               OP_LOCK:  do_lock  = 1'b1;
               OP_PROG: begin
                  if (locked || !addr_ok) refuse  = 1'b1;
                  else                    do_prog = 1'b1;
               end
               OP_READ: begin
                  if (locked || !addr_ok) refuse  = 1'b1;
                  else                    do_read = 1'b1;
               end
               default: refuse = 1'b1;
            endcase
         end
      end
   end

endmodule

// File: rtl/cfg_erase_timer.sv
module cfg_erase_timer #(
   parameter int CYCLES = 8,
   localparam int CW    = $clog2(CYCLES + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic load,
   output logic busy
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)                 cnt_q <= '0;
      else if (load)           cnt_q <= CW'(CYCLES);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);

   // R4: the window opens on the cycle after the erase is taken
   p_busy_after_load_r4: assert property (@(posedge clk) disable iff (rst)
      load |=> busy);

   // R4: the count only moves down while no new erase is taken
   p_busy_counts_down_r4: assert property (@(posedge clk) disable iff (rst)
      (busy && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/cfg_word_store.sv
module cfg_word_store #(
   parameter int DATA_W      = 16,
   parameter int TOTAL_WORDS = 134,
   parameter int ARCH_BASE   = 132,
   parameter int ARCH_BITS   = 18,
   localparam int IDX_W      = $clog2(TOTAL_WORDS)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 erase,
   input  logic                 we,
   input  logic [IDX_W-1:0]     idx,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rd_word,
   output logic [ARCH_BITS-1:0] arch_bits
);

   logic [DATA_W-1:0] mem [TOTAL_WORDS];

   always_ff @(posedge clk) begin
      if (rst || erase) begin
         for (int i = 0; i < TOTAL_WORDS; i++) mem[i] <= '1;
      end else if (we) begin
         mem[idx] <= mem[idx] & wdata;
      end
   end

   assign rd_word = mem[idx];

   for (genvar b = 0; b < ARCH_BITS; b++) begin : g_arch_bit
      assign arch_bits[b] = mem[ARCH_BASE + b / DATA_W][b % DATA_W];
   end

   // R6: a program never raises a stored bit
   p_prog_clears_only_r6: assert property (@(posedge clk) disable iff (rst)
      we |=> ((mem[$past(idx)] & ~$past(rd_word)) == '0));

endmodule

// File: rtl/cfg_image_store.sv
module cfg_image_store import cfgstore_pkg::*; #(
   parameter int DATA_W       = 16,
   parameter int ADDR_W       = 8,
   parameter int FUSE_WORDS   = 128,
   parameter int SIG_BITS     = 64,
   parameter int MACROCELLS   = 8,
   parameter int ERASE_CYCLES = 8,
   localparam int SIG_WORDS   = SIG_BITS / DATA_W,
   localparam int ARCH_BITS   = GLB_MODE_BITS + BITS_PER_CELL * MACROCELLS,
   localparam int ARCH_WORDS  = (ARCH_BITS + DATA_W - 1) / DATA_W,
   localparam int SIG_BASE    = FUSE_WORDS,
   localparam int ARCH_BASE   = SIG_BASE + SIG_WORDS,
   localparam int TOTAL_WORDS = ARCH_BASE + ARCH_WORDS,
   localparam int IDX_W       = $clog2(TOTAL_WORDS),
   localparam int CELL_W      = BITS_PER_CELL * MACROCELLS
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     cmd_valid,
   input  logic [1:0]               cmd_op,
   input  logic [ADDR_W-1:0]        cmd_addr,
   input  logic [DATA_W-1:0]        cmd_wdata,
   output logic                     busy,
   output logic                     locked,
   output logic                     rsp_valid,
   output logic                     rsp_err,
   output logic [DATA_W-1:0]        rsp_rdata,
   output logic [GLB_MODE_BITS-1:0] glb_mode,
   output logic [CELL_W-1:0]        cell_cfg
);

   // elaboration checks on the parameter set
   if (DATA_W < 2) begin : g_bad_data_w
      $error("cfg_image_store: DATA_W must be at least 2");
   end
   if ((SIG_BITS % DATA_W) != 0) begin : g_bad_sig
      $error("cfg_image_store: SIG_BITS must be a multiple of DATA_W");
   end
   if (TOTAL_WORDS > (1 << ADDR_W)) begin : g_bad_addr
      $error("cfg_image_store: ADDR_W too narrow for the image");
   end
   if (ADDR_W < IDX_W) begin : g_bad_idx
      $error("cfg_image_store: ADDR_W narrower than store index");
   end
   if (ERASE_CYCLES < 1) begin : g_bad_erase
      $error("cfg_image_store: ERASE_CYCLES must be at least 1");
   end

   cfg_op_e               op;
   logic                  do_erase, do_prog, do_read, do_lock, refuse;
   logic [IDX_W-1:0]      idx;
   logic [DATA_W-1:0]     rd_word;
   logic [ARCH_BITS-1:0]  arch_bits;
   logic                  locked_q, rsp_valid_q, rsp_err_q;
   logic [DATA_W-1:0]     rsp_rdata_q;

   assign op = cfg_op_e'(cmd_op);

   cfg_cmd_policy #(
      .ADDR_W      (ADDR_W),
      .TOTAL_WORDS (TOTAL_WORDS)
   ) u_policy (
      .cmd_valid (cmd_valid),
      .cmd_op    (op),
      .cmd_addr  (cmd_addr),
      .busy      (busy),
      .locked    (locked_q),
      .do_erase  (do_erase),
      .do_prog   (do_prog),
      .do_read   (do_read),
      .do_lock   (do_lock),
      .refuse    (refuse),
      .idx       (idx)
   );

   cfg_erase_timer #(
      .CYCLES (ERASE_CYCLES)
   ) u_timer (
      .clk  (clk),
      .rst  (rst),
      .load (do_erase),
      .busy (busy)
   );

   cfg_word_store #(
      .DATA_W      (DATA_W),
      .TOTAL_WORDS (TOTAL_WORDS),
      .ARCH_BASE   (ARCH_BASE),
      .ARCH_BITS   (ARCH_BITS)
   ) u_store (
      .clk       (clk),
      .rst       (rst),
      .erase     (do_erase),
      .we        (do_prog),
      .idx       (idx),
      .wdata     (cmd_wdata),
      .rd_word   (rd_word),
      .arch_bits (arch_bits)
   );

   always_ff @(posedge clk) begin
      if (rst)           locked_q <= 1'b0;
      else if (do_erase) locked_q <= 1'b0;
      else if (do_lock)  locked_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_valid_q <= 1'b0;
         rsp_err_q   <= 1'b0;
         rsp_rdata_q <= '0;
      end else begin
         rsp_valid_q <= cmd_valid;
         rsp_err_q   <= refuse;
         rsp_rdata_q <= do_read ? rd_word : '0;
      end
   end

   assign locked    = locked_q;
   assign rsp_valid = rsp_valid_q;
   assign rsp_err   = rsp_err_q;
   assign rsp_rdata = rsp_rdata_q;
   assign glb_mode  = arch_bits[GLB_MODE_BITS-1:0];
   assign cell_cfg  = arch_bits[ARCH_BITS-1:GLB_MODE_BITS];

   // R2: one response per presented command, one cycle later
   p_rsp_follows_cmd_r2: assert property (@(posedge clk) disable iff (rst)
      cmd_valid |=> rsp_valid);
   p_rsp_idle_r2: assert property (@(posedge clk) disable iff (rst)
      !cmd_valid |=> !rsp_valid);

   // R3: an accepted erase always releases the lock
   p_erase_unlocks_r3: assert property (@(posedge clk) disable iff (rst)
      do_erase |=> !locked);

   // R5: anything presented during the erase window is refused
   p_busy_refuse_r5: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && busy) |=> rsp_err);

   // R7: refused or non-read responses carry no data
   p_err_no_data_r7: assert property (@(posedge clk) disable iff (rst)
      rsp_err |-> (rsp_rdata == '0));

   // R8: lock takes effect and locked reads are refused
   p_lock_sets_r8: assert property (@(posedge clk) disable iff (rst)
      do_lock |=> locked);
   p_locked_read_r8: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && !busy && locked && (op == OP_READ)) |=> (rsp_err && rsp_rdata == '0));

endmodule

// File: tb/test_cfg_image_store.sv
module test_cfg_image_store;

   localparam int ERASE_CYCLES = 8;
   localparam int NV = 23;

   // entry: {op[1:0], addr[7:0], wdata[15:0], exp_err, exp_rdata[15:0]}
   localparam logic [42:0] VEC [NV] = '{
      {2'd2, 8'd0,   16'h0000, 1'b0, 16'hFFFF},  // R1 R7 erased word
      {2'd1, 8'd0,   16'hA5A5, 1'b0, 16'h0000},  // R6
      {2'd2, 8'd0,   16'h0000, 1'b0, 16'hA5A5},  // R7
      {2'd1, 8'd0,   16'h0FF0, 1'b0, 16'h0000},  // R6 second program ANDs
      {2'd2, 8'd0,   16'h0000, 1'b0, 16'h05A0},  // R6
      {2'd1, 8'd127, 16'h1234, 1'b0, 16'h0000},  // R10 last array word
      {2'd2, 8'd127, 16'h0000, 1'b0, 16'h1234},  // R10
      {2'd2, 8'd1,   16'h0000, 1'b0, 16'hFFFF},  // R6 neighbour untouched
      {2'd1, 8'd128, 16'hBEEF, 1'b0, 16'h0000},  // R10 first signature word
      {2'd2, 8'd128, 16'h0000, 1'b0, 16'hBEEF},  // R10
      {2'd1, 8'd131, 16'h00C3, 1'b0, 16'h0000},  // R10 last signature word
      {2'd2, 8'd131, 16'h0000, 1'b0, 16'h00C3},  // R10
      {2'd1, 8'd132, 16'h5A3C, 1'b0, 16'h0000},  // R10 architecture word
      {2'd2, 8'd132, 16'h0000, 1'b0, 16'h5A3C},  // R10
      {2'd2, 8'd134, 16'h0000, 1'b1, 16'h0000},  // R9 first address past store
      {2'd1, 8'd200, 16'h0000, 1'b1, 16'h0000},  // R9
      {2'd2, 8'd255, 16'h0000, 1'b1, 16'h0000},  // R9
      {2'd3, 8'd0,   16'h0000, 1'b0, 16'h0000},  // R8 lock
      {2'd2, 8'd0,   16'h0000, 1'b1, 16'h0000},  // R8 locked read
      {2'd2, 8'd128, 16'h0000, 1'b1, 16'h0000},  // R8 locked signature read
      {2'd1, 8'd133, 16'h0000, 1'b1, 16'h0000},  // R8 locked program
      {2'd3, 8'd0,   16'h0000, 1'b0, 16'h0000},  // R8 relock
      {2'd1, 8'd0,   16'h0000, 1'b1, 16'h0000}   // R8
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = 2'd0;
   logic [7:0]  cmd_addr = 8'd0;
   logic [15:0] cmd_wdata = 16'd0;
   logic        busy, locked, rsp_valid, rsp_err;
   logic [15:0] rsp_rdata, cell_cfg;
   logic [1:0]  glb_mode;

   int n_checks = 0;
   int n_fail   = 0;
   int busy_seen = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   always @(negedge clk) if (busy) busy_seen <= busy_seen + 1;

   cfg_image_store #(.ERASE_CYCLES(ERASE_CYCLES)) i_cfg_image_store (
      .clk       (clk),
      .rst       (rst),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_addr  (cmd_addr),
      .cmd_wdata (cmd_wdata),
      .busy      (busy),
      .locked    (locked),
      .rsp_valid (rsp_valid),
      .rsp_err   (rsp_err),
      .rsp_rdata (rsp_rdata),
      .glb_mode  (glb_mode),
      .cell_cfg  (cell_cfg)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive at a falling edge, accepted at the rising edge, sampled at the next falling edge
   task automatic issue(input logic [1:0] op, input logic [7:0] addr, input logic [15:0] d);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_addr  = addr;
      cmd_wdata = d;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R1 reset state
      check("R1 busy", 32'(busy), 32'd0);
      check("R1 locked", 32'(locked), 32'd0);
      check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
      check("R1 glb_mode", 32'(glb_mode), 32'h3);
      check("R1 cell_cfg", 32'(cell_cfg), 32'hFFFF);

      // vector table
      for (int i = 0; i < NV; i++) begin
         issue(VEC[i][42:41], VEC[i][40:33], VEC[i][32:17]);
         check($sformatf("R2 rsp_valid vec%0d", i), 32'(rsp_valid), 32'd1);
         check($sformatf("R7/R8/R9 rsp_err vec%0d", i), 32'(rsp_err), 32'(VEC[i][16]));
         check($sformatf("R6/R7 rsp_rdata vec%0d", i), 32'(rsp_rdata), 32'(VEC[i][15:0]));
      end

      // R2 no response without a command
      @(negedge clk);
      check("R2 idle rsp_valid", 32'(rsp_valid), 32'd0);

      // R11 decode of arch words {FFFF,5A3C}; R8 locked program left it intact
      check("R8 locked", 32'(locked), 32'd1);
      check("R11 glb_mode", 32'(glb_mode), 32'h0);
      check("R8 R11 cell_cfg", 32'(cell_cfg), 32'(((32'hFFFF << 16) | 32'h5A3C) >> 2) & 32'hFFFF);

      // R3 R4 R5 erase while locked, commands during the window
      busy_seen = 0;
      issue(2'd0, 8'd0, 16'h0000);
      check("R3 erase rsp_err", 32'(rsp_err), 32'd0);
      check("R3 erase unlocks", 32'(locked), 32'd0);
      check("R4 busy starts", 32'(busy), 32'd1);
      issue(2'd1, 8'd133, 16'h0000);
      check("R5 prog while busy err", 32'(rsp_err), 32'd1);
      issue(2'd0, 8'd0, 16'h0000);
      check("R5 erase while busy err", 32'(rsp_err), 32'd1);
      while (busy) @(negedge clk);
      @(posedge clk);
      check("R4 R5 busy length", 32'(busy_seen), 32'(ERASE_CYCLES));
      @(negedge clk);
      check("R3 R5 glb_mode", 32'(glb_mode), 32'h3);
      check("R3 R5 cell_cfg", 32'(cell_cfg), 32'hFFFF);
      issue(2'd2, 8'd0, 16'h0000);
      check("R3 array erased", 32'(rsp_rdata), 32'hFFFF);
      issue(2'd2, 8'd127, 16'h0000);
      check("R3 last array erased", 32'(rsp_rdata), 32'hFFFF);
      issue(2'd2, 8'd128, 16'h0000);
      check("R3 signature erased", 32'(rsp_rdata), 32'hFFFF);
      check("R3 read after erase err", 32'(rsp_err), 32'd0);

      // R11 field positions after unlock
      issue(2'd1, 8'd132, 16'hFFFE);
      check("R11 glb_mode bit0", 32'(glb_mode), 32'h2);
      issue(2'd1, 8'd133, 16'hFFFE);
      check("R11 cell_cfg top cell", 32'(cell_cfg), 32'hBFFF);
      check("R8 program after erase ok", 32'(rsp_err), 32'd0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule